// File: doc/BRIEF.md
# Processor Sleep and NMI-Mask Controller

This block sits on a peripheral bus next to one processor core. It holds a mask that chooses which of the core's interrupt lines also raise the non-maskable interrupt. It also holds a small sleep-control register. The block combines the interrupt lines with the mask and produces one registered NMI output.

The sleep-control register does two jobs. First, it keeps a request that the next deep sleep be handled by the wake-up interrupt controller, and it shows that controller's acknowledge, after synchronisation, as a read-only status bit. Second, it chooses whether a shallow sleep keeps the system clock request raised. When the processor sleeps and the clock request is dropped, the block holds back a resume-permission output for a fixed number of cycles after the request comes back. This covers the time the clock needs to start again.

Software reaches the registers through a zero-wait-state APB slave. A warm reset of the core clears the NMI mask but leaves the sleep-control settings as they are.

Top module: `sleep_nmi_ctrl`

## Requirements
- R1: The low mask word sits at byte offset 0x0. It is 32 bits wide, read/write, and resets to zero. Bit n enables interrupt line n (for n from 0 to 31) onto the NMI.
- R2: The high mask word sits at byte offset 0x4. Bit k enables line 32+k for the lines above 31 (with the default NUM_IRQ=52, these are bits 19:0 for lines 32 to 51). The bits above the last line ignore writes and read as zero.
- R3: While warm_rst_n is sampled low at a clock edge, both mask words are cleared. The sleep-control register keeps its value. Only rst_n returns it to its reset state.
- R4: nmi is high in the cycle after any clock edge that samples an interrupt line high together with its mask bit. It is low after any edge where no enabled line is high.
- R5: The sleep-control register sits at byte offset 0x8 and resets to 0x2. Bit 0 is the light-sleep enable (read/write, reset 0). Bit 1 is the wake-controller request (read/write, reset 1), and it drives the wic_req output.
- R6: Bit 2 of the sleep-control register reads wic_ack_in after a two-flop synchroniser, so a change appears two clock edges later. Writes to bit 2 are ignored.
- R7: clk_req is registered and resets high. After an edge that samples core_sleeping high, it goes low if core_deep_sleep is high or the light-sleep bit is 0. It stays high in a shallow sleep when the light-sleep bit is 1. It goes high again after an edge that samples the sleep as ended.
- R8: core_run_ok is low whenever clk_req is low. After clk_req rises, core_run_ok stays low for WAKE_DELAY cycles (default 5) and then rises. A sleep that keeps clk_req high never lowers core_run_ok.
- R9: APB transfers take zero wait states, so pready is always 1 and pslverr is always 0. Reads of unmapped offsets return zero, and so do offsets whose low two bits are not zero. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst_n | input | 1 | Synchronous core warm reset, active low; clears the mask |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, constant 1 |
| pslverr | output | 1 | APB error, constant 0 |
| irq | input | NUM_IRQ | Interrupt lines |
| nmi | output | 1 | Registered non-maskable interrupt |
| core_sleeping | input | 1 | Processor is in sleep |
| core_deep_sleep | input | 1 | The current sleep is a deep sleep |
| wic_ack_in | input | 1 | Acknowledge from the wake-up interrupt controller (asynchronous) |
| wic_req | output | 1 | Request for a wake-controller deep sleep |
| clk_req | output | 1 | System-level clock request |
| core_run_ok | output | 1 | Processor may resume execution |

## Verification
The bench builds the block with its default parameters, NUM_IRQ=52 and WAKE_DELAY=5. With 52 lines the high mask word is only partly implemented, so the read-as-zero bits above line 51 and NMI sources in both words can both be checked. A delay of five cycles is short enough that the bench can walk core_run_ok through every cycle of the wake-up window. It checks that the output is low in each cycle of the window and rises in the sixth cycle after clk_req returns.

// File: rtl/snc_pkg.sv
package snc_pkg;

    localparam int BUS_W = 32;

    typedef struct packed {
        logic wic_req;
        logic light;
    } sleep_cfg_t;

    localparam sleep_cfg_t CFG_RESET = '{wic_req: 1'b1, light: 1'b0};

endpackage

// File: rtl/snc_regs.sv
module snc_regs
    import snc_pkg::*;
#(
    parameter int NUM_IRQ = 52,
    parameter int ADDR_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 warm_rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [BUS_W-1:0]     pwdata,
    output logic [BUS_W-1:0]     prdata,
    input  logic                 ack_stat,
    output logic [NUM_IRQ-1:0]   mask,
    output sleep_cfg_t           cfg
);

    localparam int MASK_WORDS = (NUM_IRQ + BUS_W - 1) / BUS_W;
    localparam int PAD_W      = MASK_WORDS * BUS_W;
    localparam int IDX_W      = ADDR_W - 2;
    localparam int CTRL_IDX   = MASK_WORDS;

    typedef struct packed {
        logic [NUM_IRQ-1:0] mask;
        sleep_cfg_t         cfg;
    } regs_t;

    regs_t              r_d, r_q;
    logic               wr_en, rd_en, aligned;
    logic [IDX_W-1:0]   idx;
    logic [PAD_W-1:0]   mask_pad;

    assign aligned  = (paddr[1:0] == 2'b00);
    assign idx      = paddr[ADDR_W-1:2];
    assign wr_en    = psel && penable && pwrite && aligned;
    assign rd_en    = psel && !pwrite && aligned;
    assign mask_pad = PAD_W'(r_q.mask);

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (wr_en && idx == IDX_W'(i / BUS_W)) begin
                r_d.mask[i] = pwdata[i % BUS_W];
            end
        end
        if (wr_en && idx == IDX_W'(CTRL_IDX)) begin
            r_d.cfg.light   = pwdata[0];
            r_d.cfg.wic_req = pwdata[1];
        end
        if (!warm_rst_n) begin
            r_d.mask = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{mask: '0, cfg: CFG_RESET};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_en) begin
            for (int w = 0; w < MASK_WORDS; w++) begin
                if (idx == IDX_W'(w)) begin
                    prdata = mask_pad[w*BUS_W +: BUS_W];
                end
            end
            if (idx == IDX_W'(CTRL_IDX)) begin
                prdata = {{(BUS_W-3){1'b0}}, ack_stat, r_q.cfg.wic_req, r_q.cfg.light};
            end
        end
    end

    assign mask = r_q.mask;
    assign cfg  = r_q.cfg;

    // R3: warm reset clears the mask on the following edge
    a_r3_warm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst_n |=> (mask == '0));

    // R3: warm reset alone leaves the sleep settings untouched
    a_r3_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm_rst_n && !(psel && penable && pwrite)) |=> $stable(cfg));

    // R5: a control write lands in the request bit
    a_r5_req_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_W'(CTRL_IDX)) |=> (cfg.wic_req == $past(pwdata[1])));

    // R9: a read with no bus select returns zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |-> (prdata == '0));

endmodule

// File: rtl/snc_nmi.sv
module snc_nmi #(
    parameter int NUM_IRQ = 52
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic [NUM_IRQ-1:0] mask,
    output logic               nmi
);

    logic hit;
    logic nmi_d, nmi_q;

    assign hit = |(irq & mask);

    always_comb begin
        nmi_d = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
        end else begin
            nmi_q <= nmi_d;
        end
    end

    assign nmi = nmi_q;

    // R4: an enabled line raises the NMI one cycle later
    a_r4_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & mask) != '0) |=> nmi);

    // R4: with no enabled line high the NMI drops one cycle later
    a_r4_nmi_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & mask) == '0) |=> !nmi);

endmodule

// File: rtl/snc_sync.sv
module snc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/snc_sleep.sv
module snc_sleep #(
    parameter int WAKE_DELAY = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_sleeping,
    input  logic core_deep_sleep,
    input  logic light,
    output logic clk_req,
    output logic core_run_ok
);

    localparam int CNT_W = $clog2(WAKE_DELAY + 1) > 0 ? $clog2(WAKE_DELAY + 1) : 1;

    typedef struct packed {
        logic             clk_req;
        logic [CNT_W-1:0] cnt;
    } slp_t;

    slp_t s_d, s_q;
    logic drop;

    assign drop = core_sleeping && (core_deep_sleep || !light);

    always_comb begin
        s_d         = s_q;
        s_d.clk_req = !drop;
        if (drop) begin
            s_d.cnt = CNT_W'(WAKE_DELAY);
        end else if (s_q.clk_req && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{clk_req: 1'b1, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_req     = s_q.clk_req;
    assign core_run_ok = (s_q.cnt == '0);

    // R7: deep sleep always drops the clock request
    a_r7_deep_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (core_sleeping && core_deep_sleep) |=> !clk_req);

    // R7: shallow sleep with light-sleep set keeps the request
    a_r7_light_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (core_sleeping && !core_deep_sleep && light) |=> clk_req);

    // R7: leaving sleep restores the request
    a_r7_awake: assert property (@(posedge clk) disable iff (!rst_n)
        !core_sleeping |=> clk_req);

    // R8: no resume while the clock request is down
    a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_req |-> !core_run_ok);

    // R8: resume permission only rises with the clock request up for a cycle
    a_r8_rise_late: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run_ok) |-> (clk_req && $past(clk_req)));

endmodule

// File: rtl/sleep_nmi_ctrl.sv
module sleep_nmi_ctrl
    import snc_pkg::*;
#(
    parameter int NUM_IRQ     = 52,
    parameter int ADDR_W      = 12,
    parameter int WAKE_DELAY  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               warm_rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_IRQ-1:0] irq,
    output logic               nmi,
    input  logic               core_sleeping,
    input  logic               core_deep_sleep,
    input  logic               wic_ack_in,
    output logic               wic_req,
    output logic               clk_req,
    output logic               core_run_ok
);

    logic [NUM_IRQ-1:0] mask;
    sleep_cfg_t         cfg;
    logic               ack_stat;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    snc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (wic_ack_in),
        .dout (ack_stat)
    );

    snc_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_rst_n(warm_rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .ack_stat  (ack_stat),
        .mask      (mask),
        .cfg       (cfg)
    );

    snc_nmi #(.NUM_IRQ(NUM_IRQ)) u_nmi (
        .clk  (clk),
        .rst_n(rst_n),
        .irq  (irq),
        .mask (mask),
        .nmi  (nmi)
    );

    snc_sleep #(.WAKE_DELAY(WAKE_DELAY)) u_sleep (
        .clk            (clk),
        .rst_n          (rst_n),
        .core_sleeping  (core_sleeping),
        .core_deep_sleep(core_deep_sleep),
        .light          (cfg.light),
        .clk_req        (clk_req),
        .core_run_ok    (core_run_ok)
    );

    assign wic_req = cfg.wic_req;

    // R6: the status bit follows the acknowledge two edges late
    a_r6_ack_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stat != $past(ack_stat)) |-> (ack_stat == $past(wic_ack_in, 2)));

    // R5: the request output changes only through a bus write
    a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> $stable(wic_req));

endmodule

// File: tb/tb_sleep_nmi_ctrl.sv
module tb_sleep_nmi_ctrl;

    localparam int NUM_IRQ    = 52;
    localparam int ADDR_W     = 12;
    localparam int WAKE_DELAY = 5;
    localparam logic [31:0] HI_MASK = (32'd1 << (NUM_IRQ - 32)) - 32'd1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               warm_rst_n = 1'b1;
    logic               psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0]  paddr = '0;
    logic [31:0]        pwdata = '0;
    logic [31:0]        prdata;
    logic               pready, pslverr;
    logic [NUM_IRQ-1:0] irq = '0;
    logic               nmi;
    logic               core_sleeping = 1'b0, core_deep_sleep = 1'b0;
    logic               wic_ack_in = 1'b0;
    logic               wic_req, clk_req, core_run_ok;

    sleep_nmi_ctrl #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .WAKE_DELAY(WAKE_DELAY)) dut (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .irq(irq), .nmi(nmi), .core_sleeping(core_sleeping),
        .core_deep_sleep(core_deep_sleep), .wic_ack_in(wic_ack_in),
        .wic_req(wic_req), .clk_req(clk_req), .core_run_ok(core_run_ok)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [NUM_IRQ-1:0] mask_model = '0;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0: return prdata;
            1: return {31'b0, nmi};
            2: return {31'b0, clk_req};
            3: return {31'b0, core_run_ok};
            4: return {31'b0, wic_req};
            default: return {30'b0, pready, pslverr};
        endcase
    endfunction

    task automatic expect_now(int sel, logic [31:0] exp, string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: pops expected items and compares them with the outputs
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] obs;
            it  = exp_q.pop_front();
            obs = observe(it.sel);
            n_checks++;
            if (obs !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic apb_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(logic [ADDR_W-1:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        expect_now(0, e, tag);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic set_irq(logic [NUM_IRQ-1:0] v, string tag);
        @(negedge clk);
        irq = v;
        @(negedge clk);
        expect_now(1, {31'b0, |(v & mask_model)}, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        apb_read(12'h000, 32'h0, "R1 low mask reset");
        apb_read(12'h004, 32'h0, "R2 high mask reset");
        apb_read(12'h008, 32'h2, "R5 ctrl reset");
        expect_now(4, 32'h1, "R5 wic_req reset");
        expect_now(2, 32'h1, "R7 clk_req reset");
        expect_now(3, 32'h1, "R8 run_ok reset");
        expect_now(5, 32'h2, "R9 pready high, pslverr low");

        // mask registers
        apb_write(12'h000, 32'hA5A5_5A5A);
        apb_read(12'h000, 32'hA5A5_5A5A, "R1 low mask readback");
        apb_write(12'h004, 32'hFFFF_FFFF);
        apb_read(12'h004, HI_MASK, "R2 high mask unused bits zero");
        mask_model = {HI_MASK[NUM_IRQ-33:0], 32'hA5A5_5A5A};

        // NMI generation
        set_irq('0, "R4 no line");
        set_irq(NUM_IRQ'(1) << 3, "R4 enabled line 3");
        set_irq(NUM_IRQ'(1) << 0, "R4 masked line 0");
        set_irq(NUM_IRQ'(1) << 40, "R4 enabled line 40");
        set_irq(NUM_IRQ'(1) << (NUM_IRQ - 1), "R4 top line");

        // sleep control, bit 2 write ignored
        apb_write(12'h008, 32'h5);
        apb_read(12'h008, 32'h1, "R6 ack bit write ignored");
        expect_now(4, 32'h0, "R5 wic_req cleared");

        // warm reset
        @(negedge clk);
        warm_rst_n = 1'b0;
        @(negedge clk);
        warm_rst_n = 1'b1;
        mask_model = '0;
        apb_read(12'h000, 32'h0, "R3 low mask warm cleared");
        apb_read(12'h004, 32'h0, "R3 high mask warm cleared");
        apb_read(12'h008, 32'h1, "R3 ctrl kept over warm reset");
        set_irq(NUM_IRQ'(1) << 40, "R3 nmi off after warm reset");
        irq = '0;

        // acknowledge synchroniser
        @(negedge clk);
        wic_ack_in = 1'b1;
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = 12'h008;
        @(negedge clk);
        expect_now(0, 32'h1, "R6 ack after one edge");
        @(negedge clk);
        expect_now(0, 32'h5, "R6 ack after two edges");
        @(negedge clk);
        psel = 1'b0;
        apb_write(12'h008, 32'h3);
        apb_read(12'h008, 32'h7, "R5 request set with ack");
        expect_now(4, 32'h1, "R5 wic_req set");

        // light sleep, shallow: request held
        @(negedge clk);
        core_sleeping = 1'b1; core_deep_sleep = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            expect_now(2, 32'h1, "R7 light shallow keeps clk_req");
            expect_now(3, 32'h1, "R8 run_ok kept in light sleep");
        end
        // deep sleep drops it
        core_deep_sleep = 1'b1;
        @(negedge clk);
        expect_now(2, 32'h0, "R7 deep drops clk_req");
        expect_now(3, 32'h0, "R8 run_ok low in deep sleep");
        core_sleeping = 1'b0; core_deep_sleep = 1'b0;
        for (int k = 1; k <= WAKE_DELAY + 2; k++) begin
            @(negedge clk);
            expect_now(2, 32'h1, "R7 clk_req back after wake");
            expect_now(3, (k >= WAKE_DELAY + 1) ? 32'h1 : 32'h0, "R8 wake delay window");
        end

        // light off: shallow sleep drops the request
        apb_write(12'h008, 32'h2);
        @(negedge clk);
        core_sleeping = 1'b1;
        @(negedge clk);
        expect_now(2, 32'h0, "R7 shallow without light drops clk_req");
        core_sleeping = 1'b0;
        @(negedge clk);
        expect_now(2, 32'h1, "R7 clk_req restored");

        // unmapped and unaligned
        apb_write(12'h000, 32'h0000_0001);
        apb_read(12'h00C, 32'h0, "R9 unmapped read zero");
        apb_read(12'h002, 32'h0, "R9 unaligned read zero");
        apb_write(12'h00C, 32'hFFFF_FFFF);
        apb_write(12'h001, 32'hFFFF_FFFF);
        apb_read(12'h000, 32'h1, "R9 unmapped write no effect");
        apb_read(12'h008, 32'h6, "R9 ctrl untouched by unmapped write");
        expect_now(5, 32'h2, "R9 pready high, pslverr low");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule